// File: doc/BRIEF.md
# Parking Lot Occupancy Display

This block keeps the number of cars inside a lot that holds a fixed number of cars. It takes two single-cycle control pulses, one for a car that has come in and one for a car that has gone out. It holds the count in a saturating register, so the count can neither go below empty nor above the lot's capacity. A direction-detecting sequencer upstream produces the pulses, and this block does not contain that sequencer.

The block turns the count into glyphs for six active-low seven-segment digits. The two rightmost digits show the count in decimal. When the lot is full, the four digits above them spell FULL. When the lot is empty, the five digits above the units digit spell CLEAr, and the units digit shows 0. Two indicator outputs follow the raw levels of the two gate sensors, so a person can see when a beam is broken.

The pulses are plain control strobes. No data stream crosses the block's edge, so the block has no valid/ready handshake and no back-pressure. The count register is the only state. Every digit output is a combinational function of the registered count, so a pulse that is sampled at one clock edge is visible on the digits after that same edge.

Top module: `lot_occupancy_display`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the count to 0. With a count of 0, the display shows the empty word of R9.
- R2: When `inc_pulse` is high, `dec_pulse` is low and the count is below 25, the count rises by exactly one at that clock edge.
- R3: When the count is 25, an `inc_pulse` with `dec_pulse` low is ignored, and the display keeps showing 25 and FULL.
- R4: When `dec_pulse` is high, `inc_pulse` is low and the count is above 0, the count falls by exactly one at that clock edge.
- R5: When the count is 0, a `dec_pulse` with `inc_pulse` low is ignored, and the display keeps showing the empty word.
- R6: When `inc_pulse` and `dec_pulse` are both high in the same cycle, the count does not change, at any count including 0 and 25.
- R7: For a count from 1 to 24, `seg5` through `seg2` are blank. `seg1` shows the tens digit, or is blank when the tens digit is 0. `seg0` shows the units digit.
- R8: At a count of 25, `seg5`, `seg4`, `seg3` and `seg2` show F, U, L and L, and `seg1` and `seg0` show 2 and 5.
- R9: At a count of 0, `seg5` through `seg1` show C, L, E, A and r, and `seg0` shows 0.
- R10: Each segment output is active-low, with bit 0 driving segment a through bit 6 driving segment g. The codes are listed here in hex. Digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10. The letters are F=0E, U=41, L=47, C=46, E=06, A=08 and r=2F. Blank is 7F.
- R11: `led_red` equals `sense_a` and `led_green` equals `sense_b` at all times, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_pulse | input | 1 | One-cycle strobe: a car came in |
| dec_pulse | input | 1 | One-cycle strobe: a car went out |
| sense_a | input | 1 | Raw level of the first gate sensor |
| sense_b | input | 1 | Raw level of the second gate sensor |
| seg0 | output | 7 | Units digit, active-low, bit 0 = segment a |
| seg1 | output | 7 | Tens digit, or the letter r of the empty word |
| seg2 | output | 7 | Status digit (L of FULL, A of CLEAr) |
| seg3 | output | 7 | Status digit (L of FULL, E of CLEAr) |
| seg4 | output | 7 | Status digit (U of FULL, L of CLEAr) |
| seg5 | output | 7 | Status digit (F of FULL, C of CLEAr) |
| led_red | output | 1 | Follows sense_a |
| led_green | output | 1 | Follows sense_b |

## Verification
Two of the block's functions can meet in one cycle: an arrival pulse and a departure pulse can arrive together, and either pulse can land on a saturation boundary.

The stimulus table asserts both pulses together at a mid-range count and at 0. Directed steps repeat this at 25 and also send a lone arrival at 25 and a lone departure at 0. After each of these steps, the whole six-digit display is compared on the following falling edge with a count the bench predicts. Any wrap, double step or lost hold therefore shows up as a wrong numeral or a wrong status word.

// File: rtl/lot_pkg.sv
package lot_pkg;

  localparam int SEG_W   = 7;
  localparam int N_DIGIT = 6;

  typedef enum logic [4:0] {
    GL_0, GL_1, GL_2, GL_3, GL_4, GL_5, GL_6, GL_7, GL_8, GL_9,
    GL_F, GL_U, GL_L, GL_C, GL_E, GL_A, GL_R, GL_BLANK
  } glyph_t;

endpackage

// File: rtl/lot_sat_counter.sv
module lot_sat_counter #(
  parameter int CAPACITY = 25,
  parameter int CNT_W    = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic step_up;
  logic step_down;

  always_comb begin
    step_up   = inc && !dec && (count != CAP_V);
    step_down = dec && !inc && (count != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)            count <= '0;
    else if (step_up)   count <= count + ONE_V;
    else if (step_down) count <= count - ONE_V;
  end

  // R3 / R5: the count stays inside 0..CAPACITY
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CAP_V);

  // R2: a lone inc below the ceiling adds one
  a_r2_inc_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && count < CAP_V) |=> (count == $past(count) + ONE_V));

  // R4: a lone dec above the floor subtracts one
  a_r4_dec_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && count != '0) |=> (count == $past(count) - ONE_V));

  // R3: inc at the ceiling holds
  a_r3_hold_full: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && count == CAP_V) |=> (count == CAP_V));

  // R5: dec at the floor holds
  a_r5_hold_empty: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && count == '0) |=> (count == '0));

  // R6: simultaneous pulses leave the count alone
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(count));

endmodule

// File: rtl/lot_dec_split.sv
module lot_dec_split #(
  parameter int CNT_W = 5,
  parameter int N_DEC = 2
) (
  input  logic [CNT_W-1:0]   value,
  output logic [N_DEC*4-1:0] bcd
);

  for (genvar k = 0; k < N_DEC; k++) begin : g_digit
    localparam int WEIGHT = 10 ** k;
    always_comb begin
      bcd[k*4 +: 4] = 4'((int'(value) / WEIGHT) % 10);
    end
  end

endmodule

// File: rtl/lot_glyph_select.sv
module lot_glyph_select
  import lot_pkg::*;
#(
  parameter int CAPACITY = 25,
  parameter int CNT_W    = 5
) (
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       bcd,
  output glyph_t           glyph [N_DIGIT]
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic [3:0] tens;
  logic [3:0] units;

  always_comb begin
    tens  = bcd[7:4];
    units = bcd[3:0];
    for (int i = 0; i < N_DIGIT; i++) glyph[i] = GL_BLANK;
    glyph[0] = glyph_t'(5'(units));
    glyph[1] = (tens == 4'd0) ? GL_BLANK : glyph_t'(5'(tens));
    if (count == CAP_V) begin
      glyph[5] = GL_F;
      glyph[4] = GL_U;
      glyph[3] = GL_L;
      glyph[2] = GL_L;
    end else if (count == '0) begin
      glyph[5] = GL_C;
      glyph[4] = GL_L;
      glyph[3] = GL_E;
      glyph[2] = GL_A;
      glyph[1] = GL_R;
      glyph[0] = GL_0;
    end
  end

  // R7: the units glyph is always a numeral
  always_comb begin
    a_r7_units_numeral: assert (glyph[0] <= GL_9);
  end

endmodule

// File: rtl/lot_seg_encode.sv
module lot_seg_encode
  import lot_pkg::*;
(
  input  glyph_t           glyph,
  output logic [SEG_W-1:0] seg_n
);

  always_comb begin
    unique case (glyph)
      GL_0:     seg_n = 7'h40;
      GL_1:     seg_n = 7'h79;
      GL_2:     seg_n = 7'h24;
      GL_3:     seg_n = 7'h30;
      GL_4:     seg_n = 7'h19;
      GL_5:     seg_n = 7'h12;
      GL_6:     seg_n = 7'h02;
      GL_7:     seg_n = 7'h78;
      GL_8:     seg_n = 7'h00;
      GL_9:     seg_n = 7'h10;
      GL_F:     seg_n = 7'h0E;
      GL_U:     seg_n = 7'h41;
      GL_L:     seg_n = 7'h47;
      GL_C:     seg_n = 7'h46;
      GL_E:     seg_n = 7'h06;
      GL_A:     seg_n = 7'h08;
      GL_R:     seg_n = 7'h2F;
      default:  seg_n = 7'h7F;
    endcase
  end

endmodule

// File: rtl/lot_occupancy_display.sv
module lot_occupancy_display
  import lot_pkg::*;
#(
  parameter int CAPACITY = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_pulse,
  input  logic             dec_pulse,
  input  logic             sense_a,
  input  logic             sense_b,
  output logic [SEG_W-1:0] seg0,
  output logic [SEG_W-1:0] seg1,
  output logic [SEG_W-1:0] seg2,
  output logic [SEG_W-1:0] seg3,
  output logic [SEG_W-1:0] seg4,
  output logic [SEG_W-1:0] seg5,
  output logic             led_red,
  output logic             led_green
);

  localparam int CNT_W = $clog2(CAPACITY + 1);
  localparam int N_DEC = 2;
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic [CNT_W-1:0]   count;
  logic [N_DEC*4-1:0] bcd;
  glyph_t             glyph [N_DIGIT];
  logic [SEG_W-1:0]   seg_arr [N_DIGIT];

  lot_sat_counter #(.CAPACITY(CAPACITY), .CNT_W(CNT_W)) i_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (inc_pulse),
    .dec   (dec_pulse),
    .count (count)
  );

  lot_dec_split #(.CNT_W(CNT_W), .N_DEC(N_DEC)) i_split (
    .value (count),
    .bcd   (bcd)
  );

  lot_glyph_select #(.CAPACITY(CAPACITY), .CNT_W(CNT_W)) i_select (
    .count (count),
    .bcd   (bcd),
    .glyph (glyph)
  );

  for (genvar d = 0; d < N_DIGIT; d++) begin : g_enc
    lot_seg_encode i_enc (
      .glyph (glyph[d]),
      .seg_n (seg_arr[d])
    );
  end

  assign seg0      = seg_arr[0];
  assign seg1      = seg_arr[1];
  assign seg2      = seg_arr[2];
  assign seg3      = seg_arr[3];
  assign seg4      = seg_arr[4];
  assign seg5      = seg_arr[5];
  assign led_red   = sense_a;
  assign led_green = sense_b;

  // R8: a full lot spells FULL on the upper four digits
  a_r8_full_word: assert property (@(posedge clk) disable iff (rst)
    (count == CAP_V) |-> (seg5 == 7'h0E && seg4 == 7'h41 &&
                          seg3 == 7'h47 && seg2 == 7'h47));

  // R9: an empty lot spells CLEAr and shows 0
  a_r9_clear_word: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (seg5 == 7'h46 && seg4 == 7'h47 && seg3 == 7'h06 &&
                       seg2 == 7'h08 && seg1 == 7'h2F && seg0 == 7'h40));

  // R7: a partly filled lot leaves the upper four digits dark
  a_r7_blank_upper: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && count != CAP_V) |-> (seg5 == 7'h7F && seg4 == 7'h7F &&
                                         seg3 == 7'h7F && seg2 == 7'h7F));

  // R1: the cycle after reset shows the empty word
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (seg0 == 7'h40 && seg1 == 7'h2F));

endmodule

// File: tb/test_lot_occupancy_display.sv
module test_lot_occupancy_display;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // vector: [6]=inc, [5]=dec, [4:0]=expected count after the edge
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'd1},  {1'b1, 1'b0, 5'd2},  {1'b1, 1'b1, 5'd2},
    {1'b0, 1'b1, 5'd1},  {1'b0, 1'b1, 5'd0},  {1'b0, 1'b1, 5'd0},
    {1'b1, 1'b1, 5'd0},  {1'b1, 1'b0, 5'd1},  {1'b0, 1'b0, 5'd1},
    {1'b1, 1'b0, 5'd2},  {1'b1, 1'b0, 5'd3},  {1'b1, 1'b1, 5'd3},
    {1'b0, 1'b1, 5'd2},  {1'b1, 1'b0, 5'd3}
  };

  logic clk = 1'b0;
  logic rst, inc_pulse, dec_pulse, sense_a, sense_b;
  logic [6:0] seg0, seg1, seg2, seg3, seg4, seg5;
  logic led_red, led_green;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lot_occupancy_display i_lot_occupancy_display (
    .clk(clk), .rst(rst), .inc_pulse(inc_pulse), .dec_pulse(dec_pulse),
    .sense_a(sense_a), .sense_b(sense_b),
    .seg0(seg0), .seg1(seg1), .seg2(seg2), .seg3(seg3), .seg4(seg4),
    .seg5(seg5), .led_red(led_red), .led_green(led_green)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [6:0] num_code(int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  function automatic logic [41:0] expect_disp(int n);
    logic [6:0] t, u;
    t = (n / 10 == 0) ? 7'h7F : num_code(n / 10);
    u = num_code(n % 10);
    if (n == 25) return {7'h0E, 7'h41, 7'h47, 7'h47, num_code(2), num_code(5)};
    if (n == 0)  return {7'h46, 7'h47, 7'h06, 7'h08, 7'h2F, 7'h40};
    return {7'h7F, 7'h7F, 7'h7F, 7'h7F, t, u};
  endfunction

  task automatic check_disp(int n, string tag);
    logic [41:0] got, exp;
    got = {seg5, seg4, seg3, seg2, seg1, seg0};
    exp = expect_disp(n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s display actual %h expected %h (count %0d)", tag, got, exp, n);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic pulse(logic i, logic d);
    inc_pulse = i;
    dec_pulse = d;
    @(negedge clk);
    inc_pulse = 1'b0;
    dec_pulse = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_led(logic a, logic b, string tag);
    sense_a = a;
    sense_b = b;
    #1;
    checks++;
    if (led_red !== a || led_green !== b) begin
      errors++;
      $display("FAIL %s leds actual %b%b expected %b%b", tag, led_red, led_green, a, b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inc_pulse = 1'b0; dec_pulse = 1'b0; sense_a = 1'b0; sense_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_disp(0, "R1 reset");

    // table walk: covers R2, R4, R5, R6 and R9
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      if (VEC[v][6] && VEC[v][5])     tag = "R6 both";
      else if (VEC[v][6])             tag = "R2 inc";
      else if (VEC[v][5])             tag = (VEC[v][4:0] == 5'd0) ? "R5 dec floor" : "R4 dec";
      else                            tag = "R7 idle";
      pulse(VEC[v][6], VEC[v][5]);
      check_disp(int'(VEC[v][4:0]), tag);
    end

    // count 3 -> 12: R10 numeral codes and R7 tens digit
    for (int n = 4; n <= 12; n++) begin
      pulse(1'b1, 1'b0);
      check_disp(n, (n >= 10) ? "R7 tens" : "R10 code");
    end

    // climb to the ceiling
    for (int n = 13; n <= 25; n++) begin
      pulse(1'b1, 1'b0);
      if (n == 24 || n == 25) check_disp(n, (n == 25) ? "R8 full" : "R2 inc");
    end
    pulse(1'b1, 1'b0);
    check_disp(25, "R3 inc at full");
    pulse(1'b1, 1'b0);
    check_disp(25, "R3 inc at full again");
    pulse(1'b1, 1'b1);
    check_disp(25, "R6 both at full");
    pulse(1'b0, 1'b1);
    check_disp(24, "R4 dec from full");
    pulse(1'b1, 1'b0);
    check_disp(25, "R8 refill");

    // reset from a nonzero count
    do_reset();
    check_disp(0, "R1 reset from full");
    pulse(1'b0, 1'b1);
    check_disp(0, "R5 dec at empty");
    pulse(1'b1, 1'b1);
    check_disp(0, "R9 both at empty");

    // indicators
    check_led(1'b1, 1'b0, "R11 a only");
    check_led(1'b0, 1'b1, "R11 b only");
    check_led(1'b1, 1'b1, "R11 both");
    check_led(1'b0, 1'b0, "R11 none");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule